// File: doc/BRIEF.md
# Aligned Run Allocator for Interrupt Numbers

This block hands out interrupt numbers from a fixed pool of `NSLOTS` source slots. It keeps one used/free bit and one type bit for each slot. An allocation request asks for a run of consecutive free slots. The run can be required to start on a multiple of its own length, which is the form that multi-vector message interrupts need. An allocation can also name one specific slot. When a run is granted, the block reports the interrupt number of its first slot, which is the slot index plus the parameter `BASE`. A free request gives back a run of slots, starting from an interrupt number.

The block checks one slot per clock. The candidate start position advances by the run length when alignment is requested, and by one otherwise. The search stops with a failure as soon as the current candidate leaves too few slots before the end of the pool to hold the run. Every request ends with a single-cycle pulse, either `done` or `fail`. While the block is working, `busy` is high. A read-only query port shows the used bit and the type bit of any slot.

The controller is a state machine with six states:

- **IDLE**: waits for a request. It leaves on `req_valid` as follows:
  - to BAD when the length is illegal;
  - to FREE when a free request is in range;
  - to BAD when a free request or a named-slot request is out of range;
  - to SCAN for every other allocation.
- **SCAN**: tests one slot per cycle.
  - A used slot moves the candidate by one stride, except for a named slot, where a used slot goes to BAD.
  - A candidate that no longer fits goes to BAD.
  - When the last slot of the run tests free, the machine goes to MARK.
- **MARK**: writes one slot per cycle and goes to OK after the last slot of the run.
- **FREE**: clears one slot per cycle and goes to OK after the last slot of the run.
- **OK** and **BAD**: each lasts one cycle and returns to IDLE.

Top module: `irq_run_alloc`

## Requirements
- R1: After reset every slot reads unused with type 0, and `busy`, `done` and `fail` are low.
- R2: An unaligned allocation (`req_op`=0, `req_align`=0, `req_hint`=0) grants the lowest-numbered run of `req_len` free slots. It pulses `done` with `res_num` = `BASE` + first slot, and marks every slot of the run used.
- R3: An aligned allocation (`req_align`=1) grants only runs that start at a multiple of `req_len`, and it grants the lowest such run that is entirely free.
- R4: A length of 0, a length above `NSLOTS`, or, in an aligned allocation, a length that is not 1, 2, 4, 8, 16 or 32 pulses `fail` and `err_len` together in the same cycle, and it changes no slot.
- R5: When the next candidate start leaves fewer than `req_len` slots before the end of the pool, the allocation pulses `fail` with `err_len` low, and it changes no slot.
- R6: A named-slot allocation (`req_hint`=1, `req_op`=0) ignores `req_len` and asks for slot `req_num`-`BASE`. It succeeds with `res_num`=`req_num` when that slot is free. It fails without `err_len` when that slot is used or when `req_num` lies outside `BASE`..`BASE`+`NSLOTS`-1.
- R7: A free request (`req_op`=1) clears the `req_len` slots that start at `req_num`-`BASE` and pulses `done` with `res_num`=`req_num`. `free_warn` is high in that same cycle if at least one of those slots was already unused.
- R8: A free request whose run does not lie completely inside the pool pulses `fail`, and it clears nothing.
- R9: A granted allocation stores `req_kind` as the type bit of every slot in the run. A freed slot reads type 0. Both bits are visible on `q_used` and `q_kind` for the slot selected by `q_slot`.
- R10: `req_valid` is ignored unless the machine is in IDLE. A request raised in the cycle of a `done` or `fail` pulse is dropped with no effect.
- R11: `done` and `fail` are single-cycle pulses and never occur together. `busy` is low during either pulse, and it is low in the cycle after either pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only in IDLE |
| req_op | input | 1 | 0 = allocate, 1 = free |
| req_align | input | 1 | Allocation must start at a multiple of its length |
| req_hint | input | 1 | Allocate the single slot named by `req_num` |
| req_kind | input | 1 | Type bit to record for the granted slots |
| req_num | input | NUM_W | Interrupt number: the named slot, or the first slot to free |
| req_len | input | LEN_W | Run length |
| busy | output | 1 | Search, mark or clear in progress |
| done | output | 1 | Success pulse |
| fail | output | 1 | Failure pulse |
| err_len | output | 1 | Illegal length, high together with `fail` |
| free_warn | output | 1 | Freed run contained an already-unused slot, high together with `done` |
| res_num | output | NUM_W | First interrupt number of the run, valid with `done` |
| q_slot | input | SLOT_W | Slot index to inspect |
| q_used | output | 1 | Used bit of `q_slot` |
| q_kind | output | 1 | Type bit of `q_slot` |

## Verification
The case that matters most is a new request arriving in the same cycle that a result is completing. The bench waits for a `done` pulse and raises a free request in exactly that cycle, while the machine sits in OK. It then checks two things. First, no extra result pulse follows. Second, the query port still shows the slot that request targeted as used. The other combined case is a free request that hits a slot which is already unused: the warning must come in the same cycle as the success pulse. The scoreboard compares `free_warn` against `done` in each such case.

// File: rtl/irqa_pkg.sv
package irqa_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_MARK,
        ST_FREE,
        ST_OK,
        ST_BAD
    } irqa_state_t;

endpackage

// File: rtl/irqa_len_check.sv
// Decides whether a run length is legal and chooses the search stride.
module irqa_len_check #(
    parameter int NSLOTS    = 64,
    parameter int MAX_ALIGN = 32,
    parameter int LEN_W     = 7
) (
    input  logic [LEN_W-1:0] len,
    input  logic             align,
    output logic             legal,
    output logic [LEN_W-1:0] stride
);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(NSLOTS);
    localparam logic [LEN_W-1:0] ALN_MAX = LEN_W'(MAX_ALIGN);

    logic pow2;

    always_comb begin
        pow2   = ((len & (len - LEN_W'(1))) == '0);
        // R4: zero, oversize, and non-power-of-two aligned lengths are rejected
        legal  = (len != '0) && (len <= LEN_MAX) &&
                 (!align || (pow2 && (len <= ALN_MAX)));
        stride = align ? len : LEN_W'(1);
    end
endmodule

// File: rtl/irqa_slot_map.sv
// Holds the used bit and the type bit of every slot.
module irqa_slot_map #(
    parameter int NSLOTS = 64,
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [SLOT_W-1:0] wr_idx,
    input  logic              wr_kind,
    input  logic [SLOT_W-1:0] rd_idx,
    output logic              rd_used,
    input  logic [SLOT_W-1:0] q_idx,
    output logic              q_used,
    output logic              q_kind
);
    logic [NSLOTS-1:0] used_q;
    logic [NSLOTS-1:0] kind_q;

    for (genvar s = 0; s < NSLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                used_q[s] <= 1'b0;
                kind_q[s] <= 1'b0;
            end else if (set_en && (wr_idx == SLOT_W'(s))) begin
                used_q[s] <= 1'b1;
                kind_q[s] <= wr_kind;
            end else if (clr_en && (wr_idx == SLOT_W'(s))) begin
                used_q[s] <= 1'b0;
                kind_q[s] <= 1'b0;
            end
        end
    end

    assign rd_used = used_q[rd_idx];
    assign q_used  = used_q[q_idx];
    assign q_kind  = kind_q[q_idx];
endmodule

// File: rtl/irqa_seq.sv
// Request state machine: stride search, marking and clearing, one slot per clock.
module irqa_seq
    import irqa_pkg::*;
#(
    parameter int NSLOTS = 64,
    parameter int BASE   = 4096,
    parameter int NUM_W  = 16,
    parameter int SLOT_W = 6,
    parameter int LEN_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_op,
    input  logic              req_align,
    input  logic              req_hint,
    input  logic              req_kind,
    input  logic [NUM_W-1:0]  req_num,
    input  logic [LEN_W-1:0]  req_len,
    output logic [LEN_W-1:0]  chk_len,
    output logic              chk_align,
    input  logic              len_ok,
    input  logic [LEN_W-1:0]  len_stride,
    output logic [SLOT_W-1:0] slot_idx,
    input  logic              rd_used,
    output logic              set_en,
    output logic              clr_en,
    output logic              wr_kind,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic              err_len,
    output logic              free_warn,
    output logic [NUM_W-1:0]  res_num
);
    localparam int CW = SLOT_W + 2;
    localparam logic [NUM_W-1:0] BASE_V  = NUM_W'(BASE);
    localparam logic [CW-1:0]    SLOTS_C = CW'(NSLOTS);

    irqa_state_t st_q, st_d;

    logic [CW-1:0]    cand_q;
    logic [LEN_W-1:0] idx_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] stride_q;
    logic             kind_q;
    logic             hint_q;
    logic             warn_q;
    logic             bad_len_q;

    logic [NUM_W-1:0] off_full;
    logic             range_ok;
    logic             run_in_map;
    logic             fits;
    logic             last;

    // Request decode
    always_comb begin
        chk_len    = (req_hint && !req_op) ? LEN_W'(1) : req_len;
        chk_align  = req_align && !req_op && !req_hint;
        off_full   = req_num - BASE_V;
        range_ok   = (req_num >= BASE_V) && (off_full < NUM_W'(NSLOTS));
        run_in_map = ({1'b0, off_full} + (NUM_W+1)'(req_len)) <= (NUM_W+1)'(NSLOTS);
        fits       = (cand_q + CW'(len_q)) <= SLOTS_C;
        last       = (idx_q == (len_q - LEN_W'(1)));
        slot_idx   = SLOT_W'(cand_q + CW'(idx_q));
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!len_ok)       st_d = ST_BAD;
                    else if (req_op)   st_d = (range_ok && run_in_map) ? ST_FREE : ST_BAD;
                    else if (req_hint) st_d = range_ok ? ST_SCAN : ST_BAD;
                    else               st_d = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (!fits)        st_d = ST_BAD;   // R5: early give-up
                else if (rd_used) begin
                    if (hint_q)   st_d = ST_BAD;   // R6: named slot taken
                end
                else if (last)    st_d = ST_MARK;
            end
            ST_MARK: if (last) st_d = ST_OK;
            ST_FREE: if (last) st_d = ST_OK;
            ST_OK:   st_d = ST_IDLE;
            ST_BAD:  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q    <= '0;
            idx_q     <= '0;
            len_q     <= LEN_W'(1);
            stride_q  <= LEN_W'(1);
            kind_q    <= 1'b0;
            hint_q    <= 1'b0;
            warn_q    <= 1'b0;
            bad_len_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        len_q     <= chk_len;
                        stride_q  <= len_stride;
                        kind_q    <= req_kind;
                        hint_q    <= req_hint;
                        idx_q     <= '0;
                        warn_q    <= 1'b0;
                        bad_len_q <= !len_ok;
                        cand_q    <= (req_op || req_hint) ? CW'(off_full) : '0;
                    end
                end
                ST_SCAN: begin
                    if (fits) begin
                        if (rd_used) begin
                            // R3: the next candidate lies one stride further on
                            cand_q <= cand_q + CW'(stride_q);
                            idx_q  <= '0;
                        end else if (last) begin
                            idx_q  <= '0;
                        end else begin
                            idx_q  <= idx_q + LEN_W'(1);
                        end
                    end
                end
                ST_MARK: idx_q <= idx_q + LEN_W'(1);
                ST_FREE: begin
                    idx_q  <= idx_q + LEN_W'(1);
                    warn_q <= warn_q | !rd_used;     // R7
                end
                ST_OK, ST_BAD: idx_q <= '0;
                default: idx_q <= '0;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy      = (st_q == ST_SCAN) || (st_q == ST_MARK) || (st_q == ST_FREE);
        done      = (st_q == ST_OK);
        fail      = (st_q == ST_BAD);
        err_len   = (st_q == ST_BAD) && bad_len_q;
        free_warn = (st_q == ST_OK) && warn_q;
        set_en    = (st_q == ST_MARK);
        clr_en    = (st_q == ST_FREE);
        wr_kind   = kind_q;
        res_num   = BASE_V + NUM_W'(cand_q);
    end
endmodule

// File: rtl/irq_run_alloc.sv
module irq_run_alloc #(
    parameter int  NSLOTS    = 64,
    parameter int  BASE      = 4096,
    parameter int  NUM_W     = 16,
    parameter int  MAX_ALIGN = 32,
    localparam int SLOT_W    = $clog2(NSLOTS),
    localparam int LEN_W     = $clog2(NSLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_op,
    input  logic              req_align,
    input  logic              req_hint,
    input  logic              req_kind,
    input  logic [NUM_W-1:0]  req_num,
    input  logic [LEN_W-1:0]  req_len,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic              err_len,
    output logic              free_warn,
    output logic [NUM_W-1:0]  res_num,
    input  logic [SLOT_W-1:0] q_slot,
    output logic              q_used,
    output logic              q_kind
);
    logic [LEN_W-1:0]  chk_len;
    logic              chk_align;
    logic              len_ok;
    logic [LEN_W-1:0]  len_stride;
    logic [SLOT_W-1:0] slot_idx;
    logic              rd_used;
    logic              set_en;
    logic              clr_en;
    logic              wr_kind;

    irqa_len_check #(
        .NSLOTS(NSLOTS), .MAX_ALIGN(MAX_ALIGN), .LEN_W(LEN_W)
    ) u_len (
        .len(chk_len), .align(chk_align), .legal(len_ok), .stride(len_stride)
    );

    irqa_slot_map #(
        .NSLOTS(NSLOTS), .SLOT_W(SLOT_W)
    ) u_map (
        .clk(clk), .rst_n(rst_n),
        .set_en(set_en), .clr_en(clr_en),
        .wr_idx(slot_idx), .wr_kind(wr_kind),
        .rd_idx(slot_idx), .rd_used(rd_used),
        .q_idx(q_slot), .q_used(q_used), .q_kind(q_kind)
    );

    irqa_seq #(
        .NSLOTS(NSLOTS), .BASE(BASE), .NUM_W(NUM_W),
        .SLOT_W(SLOT_W), .LEN_W(LEN_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_align(req_align),
        .req_hint(req_hint), .req_kind(req_kind),
        .req_num(req_num), .req_len(req_len),
        .chk_len(chk_len), .chk_align(chk_align),
        .len_ok(len_ok), .len_stride(len_stride),
        .slot_idx(slot_idx), .rd_used(rd_used),
        .set_en(set_en), .clr_en(clr_en), .wr_kind(wr_kind),
        .busy(busy), .done(done), .fail(fail),
        .err_len(err_len), .free_warn(free_warn), .res_num(res_num)
    );
endmodule

// File: rtl/irqa_checker.sv
module irqa_checker #(
    parameter int NSLOTS = 64,
    parameter int BASE   = 4096,
    parameter int NUM_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             fail,
    input logic             err_len,
    input logic             free_warn,
    input logic [NUM_W-1:0] res_num
);
    // R11
    a_r11_done_fail_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r11_fail_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> !fail);
    a_r11_quiet_after: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail) |=> !busy);
    a_r11_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(done || fail));
    // R4
    a_r4_err_with_fail: assert property (@(posedge clk) disable iff (!rst_n)
        err_len |-> fail);
    // R7
    a_r7_warn_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        free_warn |-> done);
    // R2
    a_r2_result_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((res_num >= NUM_W'(BASE)) && (res_num < NUM_W'(BASE + NSLOTS))));
endmodule

bind irq_run_alloc irqa_checker #(
    .NSLOTS(NSLOTS), .BASE(BASE), .NUM_W(NUM_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fail(fail),
    .err_len(err_len), .free_warn(free_warn), .res_num(res_num)
);

// File: tb/irq_run_alloc_test.sv
`timescale 1ns/1ps
module irq_run_alloc_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_op = 1'b0, req_align = 1'b0;
    logic        req_hint = 1'b0, req_kind = 1'b0;
    logic [15:0] req_num = '0;
    logic [6:0]  req_len = '0;
    logic        busy, done, fail, err_len, free_warn, q_used, q_kind;
    logic [15:0] res_num;
    logic [5:0]  q_slot = '0;

    int n_chk = 0, n_err = 0, n_sent = 0, n_seen = 0;

    typedef struct {
        logic        f;
        logic        e;
        logic        w;
        logic [15:0] n;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    irq_run_alloc uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_align(req_align), .req_hint(req_hint), .req_kind(req_kind),
        .req_num(req_num), .req_len(req_len), .busy(busy), .done(done),
        .fail(fail), .err_len(err_len), .free_warn(free_warn),
        .res_num(res_num), .q_slot(q_slot), .q_used(q_used), .q_kind(q_kind)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected item for every result pulse
    always @(negedge clk) begin
        if (rst_n && (done || fail)) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R10 unexpected result pulse", {30'd0, done, fail}, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(fail == e.f, {e.tag, " fail"}, fail, e.f);
                chk(err_len == e.e, {e.tag, " err_len"}, err_len, e.e);
                chk(free_warn == e.w, {e.tag, " free_warn"}, free_warn, e.w);
                if (!e.f) chk(res_num == e.n, {e.tag, " res_num"}, res_num, e.n);
                n_seen++;
            end
        end
    end

    task automatic issue(input logic op, input logic al, input logic hn,
                         input logic kd, input logic [15:0] num, input logic [6:0] len);
        @(negedge clk);
        req_op = op; req_align = al; req_hint = hn; req_kind = kd;
        req_num = num; req_len = len; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_res(input logic f, input logic e, input logic w,
                              input logic [15:0] n, input string tag);
        exp_t x;
        x.f = f; x.e = e; x.w = w; x.n = n; x.tag = tag;
        sb.push_back(x);
        n_sent++;
    endtask

    task automatic run(input logic op, input logic al, input logic hn, input logic kd,
                       input logic [15:0] num, input logic [6:0] len,
                       input logic f, input logic e, input logic w,
                       input logic [15:0] n, input string tag);
        expect_res(f, e, w, n, tag);
        issue(op, al, hn, kd, num, len);
        wait (n_seen == n_sent);
        @(negedge clk);
    endtask

    task automatic look(input logic [5:0] s, input logic eu, input logic ek, input string tag);
        @(negedge clk);
        q_slot = s;
        #1;
        chk(q_used == eu, {tag, " used"}, q_used, eu);
        chk(q_kind == ek, {tag, " kind"}, q_kind, ek);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_seen, n_sent);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({busy, done, fail} == 3'b000, "R1 idle outputs", {busy, done, fail}, 0);
        look(6'd0, 1'b0, 1'b0, "R1 slot0");
        look(6'd63, 1'b0, 1'b0, "R1 slot63");

        // R2 unaligned first fit, check busy during search (R11)
        expect_res(0, 0, 0, 16'h1000, "R2 len3");
        issue(0, 0, 0, 1, 16'h0, 7'd3);
        chk(busy == 1'b1, "R11 busy during search", busy, 1);
        wait (n_seen == n_sent);
        @(negedge clk);
        // R3 aligned len4 skips candidate 0
        run(0, 1, 0, 0, 16'h0, 7'd4, 0, 0, 0, 16'h1004, "R3 aligned4");
        run(0, 0, 0, 0, 16'h0, 7'd1, 0, 0, 0, 16'h1003, "R2 fill gap");
        // R4 illegal lengths
        run(0, 1, 0, 0, 16'h0, 7'd3, 1, 1, 0, 16'h0, "R4 aligned3");
        run(0, 0, 0, 0, 16'h0, 7'd0, 1, 1, 0, 16'h0, "R4 len0");
        run(0, 1, 0, 0, 16'h0, 7'd64, 1, 1, 0, 16'h0, "R4 aligned64");
        // R6 named slot
        run(0, 0, 1, 0, 16'h1002, 7'd9, 1, 0, 0, 16'h0, "R6 hint used");
        run(0, 0, 1, 0, 16'h1010, 7'd9, 0, 0, 0, 16'h1010, "R6 hint free");
        run(0, 0, 1, 0, 16'h2000, 7'd1, 1, 0, 0, 16'h0, "R6 hint range");
        // R3 more aligned runs
        run(0, 1, 0, 0, 16'h0, 7'd8, 0, 0, 0, 16'h1008, "R3 aligned8");
        run(0, 1, 0, 1, 16'h0, 7'd32, 0, 0, 0, 16'h1020, "R3 aligned32");
        // R5 early give-up
        run(0, 1, 0, 0, 16'h0, 7'd16, 1, 0, 0, 16'h0, "R5 aligned16 none");
        run(0, 0, 0, 0, 16'h0, 7'd15, 0, 0, 0, 16'h1011, "R2 len15");
        run(0, 0, 0, 0, 16'h0, 7'd1, 1, 0, 0, 16'h0, "R5 pool full");
        // R9 type bits
        look(6'd0, 1'b1, 1'b1, "R9 slot0");
        look(6'd4, 1'b1, 1'b0, "R9 slot4");
        look(6'd40, 1'b1, 1'b1, "R9 slot40");
        // R7 free
        run(1, 0, 0, 0, 16'h1000, 7'd3, 0, 0, 0, 16'h1000, "R7 free3");
        look(6'd1, 1'b0, 1'b0, "R9 freed slot1");
        run(1, 0, 0, 0, 16'h1000, 7'd4, 0, 0, 1, 16'h1000, "R7 free warn");
        look(6'd3, 1'b0, 1'b0, "R7 slot3 cleared");
        // R8 out of range free
        run(1, 0, 0, 0, 16'h1030, 7'd32, 1, 0, 0, 16'h0, "R8 free overrun");
        look(6'd48, 1'b1, 1'b1, "R8 slot48 kept");

        // R10 request in the pulse cycle is dropped
        expect_res(0, 0, 0, 16'h1000, "R10 alloc before drop");
        issue(0, 0, 0, 0, 16'h0, 7'd1);
        while (!(done || fail)) @(negedge clk);
        req_op = 1'b1; req_align = 1'b0; req_hint = 1'b0;
        req_num = 16'h1004; req_len = 7'd4; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (20) @(negedge clk);
        chk(n_seen == n_sent, "R10 result count", n_seen, n_sent);
        look(6'd4, 1'b1, 1'b0, "R10 slot4 kept");
        chk(busy == 1'b0, "R10 idle", busy, 0);
        summary();
    end
endmodule